// File: doc/BRIEF.md
# Register-Mapped Serial Transmitter

This block is the transmit half of an asynchronous serial port that hangs off a small byte-wide register bus. Software sets the character format and the bit rate through control registers, then writes characters into a data register. Each character waits in a one-deep holding buffer until the shift stage is free, and then leaves on a single output line as a framed asynchronous character.

The character length runs from 5 to 9 bits. Parity can be even, odd or absent, and a frame ends with one or two stop bits. The bit period comes from a 12-bit divisor and an oversampling factor of 16, or 8 in double-speed mode. Two level interrupt requests report that the holding buffer can accept a new character and that the line has drained. Each request has its own enable and its own acknowledge input, and the acknowledge clears the flag behind it.

Top module: `utx_periph`

## Requirements
- R1: Registers are byte-addressed: status at 0, control-1 at 1, control-2 at 2, divisor low at 4, divisor high at 5 (low 4 bits used, upper bits read 0), data at 6. Offset 3 and the data offset read 0. Read data appears one clock after the address is presented.
- R2: The line idles high. A frame is a low start bit, then the data bits LSB first, then the parity bit if enabled, then the stop bits, which are high.
- R3: The size code is {control-1 bit 2, control-2 bits 2:1}. Codes 0..3 give 5..8 data bits. Code 7 and the reserved codes 4..6 give 9 bits. In 9-bit mode the ninth data bit is control-1 bit 0, as it stood when the data register was written.
- R4: Control-2 bits 5:4 select parity: 00 and 01 mean none, 10 means even, 11 means odd. Control-2 bit 3 selects two stop bits when 1 and one stop bit when 0.
- R5: Every bit lasts M*(divisor+1) clocks. M is 8 when status bit 1 (double speed) is set and 16 when it is clear.
- R6: A data write is taken only while control-1 bit 3 (transmit enable) is 1. A write taken clears the empty flag (status bit 5). The character moves into the shifter once the shifter is idle, and that move sets the empty flag again. Two writes in a row send two frames in order. A write made while transmit enable is 0 has no effect and sends nothing.
- R7: Writing control-1 so that bit 3 goes from 0 to 1 sets the empty flag. Rewriting bit 3 as 1 when it is already 1 leaves the flag unchanged.
- R8: The complete flag (status bit 6) sets after the last stop bit has left the line and no character is pending. It stays 0 while a frame is in flight. Writing 1 to status bit 6 clears it, and writing 0 there has no effect.
- R9: irq_empty is high while the empty flag and control-1 bit 5 are both 1. A pulse on irq_empty_ack clears the empty flag.
- R10: irq_done is high while the complete flag and control-1 bit 6 are both 1. A pulse on irq_done_ack clears the complete flag.
- R11: After reset the line is high, status reads 0x20, control-2 reads 0x06 (8 data bits) and both requests are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data for the address of the previous cycle |
| irq_empty_ack | input | 1 | Acknowledge of the buffer-empty request |
| irq_done_ack | input | 1 | Acknowledge of the transmit-complete request |
| irq_empty | output | 1 | Buffer-empty interrupt request (level) |
| irq_done | output | 1 | Transmit-complete interrupt request (level) |
| tx_out | output | 1 | Serial output line |

## Verification
The bench sends a set of frames, each with a different format, and compares the line bit by bit against a frame it builds itself. An 8-bit frame with no parity checks the bit order. A 5-bit frame with even parity and two stop bits checks the data mask and the stop count. A 7-bit frame with odd parity and a 9-bit frame with the ninth bit set check the parity sense and the split size code. A reserved size code must give the same result as 9 bits, and parity mode 01 must drop the parity bit. The bench measures the start-bit length at two divisor and speed settings, so an error in the oversampling factor shows apart from an error in the divisor. It also sends two back-to-back characters, which shows whether the buffer and shifter hand over in the right order, and makes a write while transmit enable is 0, which must leave the line quiet.

// File: rtl/utx_pkg.sv
package utx_pkg;
  localparam int ADDR_W    = 3;
  localparam int MAX_DATA  = 9;
  localparam int FRAME_W   = 1 + MAX_DATA + 1 + 2;
  localparam int LEN_W     = $clog2(FRAME_W + 1);
  localparam int OS_NORMAL = 16;
  localparam int OS_W      = $clog2(OS_NORMAL);

  localparam logic [ADDR_W-1:0] A_STAT  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTL1  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTL2  = 3'd2;
  localparam logic [ADDR_W-1:0] A_DIVLO = 3'd4;
  localparam logic [ADDR_W-1:0] A_DIVHI = 3'd5;
  localparam logic [ADDR_W-1:0] A_DATA  = 3'd6;

  function automatic logic [3:0] size_bits(input logic [2:0] code);
    case (code)
      3'd0: size_bits = 4'd5;
      3'd1: size_bits = 4'd6;
      3'd2: size_bits = 4'd7;
      3'd3: size_bits = 4'd8;
      default: size_bits = 4'd9;
    endcase
  endfunction
endpackage

// File: rtl/utx_baud.sv
module utx_baud
  import utx_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             dbl,
  input  logic [DIV_W-1:0] div,
  output logic             bit_tick
);
  logic [DIV_W-1:0] pre_q;
  logic [OS_W-1:0]  sub_q;
  logic [OS_W-1:0]  sub_last;

  assign sub_last = dbl ? OS_W'(OS_NORMAL/2 - 1) : OS_W'(OS_NORMAL - 1);
  assign bit_tick = run && (pre_q == div) && (sub_q == sub_last);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre_q <= '0;
      sub_q <= '0;
    end else if (pre_q == div) begin
      pre_q <= '0;
      sub_q <= (sub_q == sub_last) ? '0 : sub_q + 1'b1;
    end else begin
      pre_q <= pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/utx_framer.sv
module utx_framer
  import utx_pkg::*;
(
  input  logic [MAX_DATA-1:0] data,
  input  logic [2:0]          size_code,
  input  logic [1:0]          par_mode,
  input  logic                stop2,
  output logic [FRAME_W-1:0]  frame,
  output logic [LEN_W-1:0]    len
);
  logic [3:0]          nbits;
  logic [MAX_DATA-1:0] mask;
  logic                par;
  logic [FRAME_W-1:0]  zeros;

  always_comb begin
    nbits = size_bits(size_code);
    mask  = {MAX_DATA{1'b1}} >> (4'(MAX_DATA) - nbits);
    par   = par_mode[0] ^ (^(data & mask));
    // Low bits of the frame: start bit plus every data bit that is 0.
    zeros = ({{(FRAME_W-MAX_DATA){1'b0}}, ~data & mask} << 1) | FRAME_W'(1);
    if (par_mode[1] && !par)
      zeros = zeros | (FRAME_W'(1) << (nbits + 4'd1));
    frame = ~zeros;
    len   = LEN_W'(4'd2 + nbits + {3'b000, par_mode[1]} + {3'b000, stop2});
  end
endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
  import utx_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame_in,
  input  logic [LEN_W-1:0]   len_in,
  input  logic               bit_tick,
  output logic               tx_out,
  output logic               busy,
  output logic               done
);
  logic [FRAME_W-1:0] shreg_q;
  logic [LEN_W-1:0]   left_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '1;
      left_q  <= '0;
      busy    <= 1'b0;
      tx_out  <= 1'b1;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load && !busy) begin
        tx_out  <= frame_in[0];
        shreg_q <= frame_in >> 1;
        left_q  <= len_in;
        busy    <= 1'b1;
      end else if (busy && bit_tick) begin
        if (left_q == LEN_W'(1)) begin
          busy   <= 1'b0;
          tx_out <= 1'b1;
          done   <= 1'b1;
        end else begin
          tx_out  <= shreg_q[0];
          shreg_q <= shreg_q >> 1;
          left_q  <= left_q - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/utx_periph.sv
module utx_periph
  import utx_pkg::*;
#(
  parameter int DIV_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              irq_empty_ack,
  input  logic              irq_done_ack,
  output logic              irq_empty,
  output logic              irq_done,
  output logic              tx_out
);
  localparam int HI_W = DIV_W - 8;

  logic             u2x_q;
  logic [7:0]       ctl1_q;
  logic [7:0]       ctl2_q;
  logic [DIV_W-1:0] div_q;
  logic [7:0]       buf_q;
  logic             buf_ninth_q;
  logic             buf_full;
  logic             udre;
  logic             txc;

  logic             data_acc;
  logic             txen_rise;
  logic             load;
  logic             busy;
  logic             done;
  logic             bit_tick;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   len;
  logic [15:0]        div_ext;

  assign data_acc  = bus_wr && (bus_addr == A_DATA) && ctl1_q[3];
  assign txen_rise = bus_wr && (bus_addr == A_CTL1) && bus_wdata[3] && !ctl1_q[3];
  assign load      = buf_full && !busy;
  assign div_ext   = 16'(div_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      u2x_q       <= 1'b0;
      ctl1_q      <= 8'h00;
      ctl2_q      <= 8'h06;
      div_q       <= '0;
      buf_q       <= 8'h00;
      buf_ninth_q <= 1'b0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_STAT:  u2x_q <= bus_wdata[1];
        A_CTL1:  ctl1_q <= bus_wdata & 8'hFD;
        A_CTL2:  ctl2_q <= bus_wdata;
        A_DIVLO: div_q[7:0] <= bus_wdata;
        A_DIVHI: div_q[DIV_W-1:8] <= bus_wdata[HI_W-1:0];
        A_DATA: if (ctl1_q[3]) begin
          buf_q       <= bus_wdata;
          buf_ninth_q <= ctl1_q[0];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_full <= 1'b0;
      udre     <= 1'b1;
      txc      <= 1'b0;
    end else begin
      if (data_acc)      buf_full <= 1'b1;
      else if (load)     buf_full <= 1'b0;

      if (data_acc)                   udre <= 1'b0;
      else if (load || txen_rise)     udre <= 1'b1;
      else if (irq_empty_ack)         udre <= 1'b0;

      if (done && !buf_full && !data_acc)
        txc <= 1'b1;
      else if (irq_done_ack || (bus_wr && bus_addr == A_STAT && bus_wdata[6]))
        txc <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= 8'h00;
    end else begin
      case (bus_addr)
        A_STAT:  bus_rdata <= {1'b0, txc, udre, 3'b000, u2x_q, 1'b0};
        A_CTL1:  bus_rdata <= ctl1_q;
        A_CTL2:  bus_rdata <= ctl2_q;
        A_DIVLO: bus_rdata <= div_ext[7:0];
        A_DIVHI: bus_rdata <= div_ext[15:8];
        default: bus_rdata <= 8'h00;
      endcase
    end
  end

  assign irq_empty = udre & ctl1_q[5];
  assign irq_done  = txc & ctl1_q[6];

  utx_framer u_framer (
    .data      ({buf_ninth_q, buf_q}),
    .size_code ({ctl1_q[2], ctl2_q[2:1]}),
    .par_mode  (ctl2_q[5:4]),
    .stop2     (ctl2_q[3]),
    .frame     (frame),
    .len       (len)
  );

  utx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk      (clk),
    .rst      (rst),
    .run      (busy),
    .dbl      (u2x_q),
    .div      (div_q),
    .bit_tick (bit_tick)
  );

  utx_shifter u_shift (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .frame_in (frame),
    .len_in   (len),
    .bit_tick (bit_tick),
    .tx_out   (tx_out),
    .busy     (busy),
    .done     (done)
  );
endmodule

// File: rtl/utx_checker.sv
module utx_checker (
  input logic clk,
  input logic rst,
  input logic tx_out,
  input logic busy,
  input logic bit_tick,
  input logic done,
  input logic buf_full,
  input logic data_acc,
  input logic udre,
  input logic txc,
  input logic irq_done_ack
);
  // R2: line is high whenever no frame is in flight
  p_idle_high_r2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> tx_out);

  // R2: a frame begins with the start bit on the line
  p_start_low_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !tx_out);

  // R5: inside a frame the line only moves on a bit boundary
  p_bit_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$past(bit_tick)) |-> $stable(tx_out));

  // R6: moving a character into the shifter refills the empty flag
  p_load_refills_r6: assert property (@(posedge clk) disable iff (rst)
    ($rose(busy) && !$past(data_acc)) |-> udre);

  // R8: complete flag rises only with an idle shifter and nothing pending
  p_txc_drained_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(txc) |-> (!busy && !buf_full));

  // R10: acknowledge clears the complete flag unless it is being set again
  p_ack_clears_txc_r10: assert property (@(posedge clk) disable iff (rst)
    (irq_done_ack && txc && !(done && !buf_full && !data_acc)) |=> !txc);
endmodule

bind utx_periph utx_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .tx_out       (tx_out),
  .busy         (busy),
  .bit_tick     (bit_tick),
  .done         (done),
  .buf_full     (buf_full),
  .data_acc     (data_acc),
  .udre         (udre),
  .txc          (txc),
  .irq_done_ack (irq_done_ack)
);

// File: tb/utx_periph_test.sv
module utx_periph_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] bus_addr = 3'd0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       irq_empty_ack = 1'b0;
  logic       irq_done_ack = 1'b0;
  logic       irq_empty;
  logic       irq_done;
  logic       tx_out;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  utx_periph uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_empty_ack(irq_empty_ack), .irq_done_ack(irq_done_ack),
    .irq_empty(irq_empty), .irq_done(irq_done), .tx_out(tx_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic pulse_ack(input bit empty_side);
    @(negedge clk);
    if (empty_side) irq_empty_ack = 1'b1; else irq_done_ack = 1'b1;
    @(negedge clk);
    irq_empty_ack = 1'b0; irq_done_ack = 1'b0;
  endtask

  function automatic logic [12:0] exp_frame(input logic [8:0] d, input int n,
                                            input logic [1:0] pm, input bit st2,
                                            output int len);
    logic [12:0] f = '1;
    logic [8:0]  t;
    int pos = 1;
    bit p = 1'b0;
    f = f & ~13'd1;
    for (int i = 0; i < n; i++) begin
      t = d >> i;
      if (!t[0]) f = f & ~(13'd1 << pos);
      p = p ^ t[0];
      pos++;
    end
    if (pm[1]) begin
      if (!(pm[0] ? !p : p)) f = f & ~(13'd1 << pos);
      pos++;
    end
    len = pos + 1 + (st2 ? 1 : 0);
    return f;
  endfunction

  task automatic capture(input int p, input int len, output logic [12:0] bits);
    int guard = 0;
    bits = '0;
    do begin
      @(negedge clk);
      guard++;
    end while (tx_out === 1'b1 && guard < 5000);
    repeat (p/2) @(negedge clk);
    bits = bits | 13'(tx_out);
    for (int k = 1; k < len; k++) begin
      repeat (p) @(negedge clk);
      bits = bits | (13'(tx_out) << k);
    end
    bits = bits | ~((13'd1 << len) - 13'd1);
  endtask

  task automatic measure_start(output int cnt);
    int guard = 0;
    cnt = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (tx_out === 1'b1 && guard < 5000);
    while (tx_out === 1'b0 && cnt < 5000) begin
      cnt++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [7:0] rd;
    chk(tx_out === 1'b1, "R11 idle line", int'(tx_out), 1);
    chk(irq_empty === 1'b0 && irq_done === 1'b0, "R11 requests low",
        int'({irq_empty, irq_done}), 0);
    bus_read(3'd0, rd);
    chk(rd === 8'h20, "R11 status", int'(rd), 'h20);
    bus_read(3'd2, rd);
    chk(rd === 8'h06, "R11 control-2", int'(rd), 'h06);
  endtask

  task automatic t_regs();
    logic [7:0] rd;
    bus_write(3'd4, 8'h34);
    bus_write(3'd5, 8'hFA);
    bus_read(3'd5, rd);
    chk(rd === 8'h0A, "R1 divisor high", int'(rd), 'h0A);
    bus_read(3'd4, rd);
    chk(rd === 8'h34, "R1 divisor low", int'(rd), 'h34);
    bus_write(3'd3, 8'hFF);
    bus_read(3'd3, rd);
    chk(rd === 8'h00, "R1 offset 3", int'(rd), 0);
    bus_write(3'd4, 8'h00);
    bus_write(3'd5, 8'h00);
  endtask

  task automatic t_disabled();
    logic [7:0] rd;
    int lows = 0;
    bus_write(3'd6, 8'h00);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tx_out !== 1'b1) lows++;
    end
    chk(lows == 0, "R6 write while disabled sends nothing", lows, 0);
    bus_write(3'd1, 8'h08);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (tx_out !== 1'b1) lows++;
    end
    chk(lows == 0, "R6 no pending character after enable", lows, 0);
    bus_read(3'd6, rd);
    chk(rd === 8'h00, "R1 data offset reads 0", int'(rd), 0);
  endtask

  task automatic t_frame(input string req, input logic [7:0] d, input bit ninth,
                         input logic [2:0] code, input logic [1:0] pm, input bit st2);
    logic [12:0] got, exp;
    int len;
    int n = (code < 3'd4) ? int'(code) + 5 : 9;
    bus_write(3'd0, 8'h02);
    bus_write(3'd2, {2'b00, pm, st2, code[1:0], 1'b0});
    bus_write(3'd1, {4'b0000, 1'b1, code[2], 1'b0, ninth});
    exp = exp_frame({ninth, d}, n, pm, st2, len);
    bus_write(3'd6, d);
    capture(8, len, got);
    chk(got === exp, req, int'(got), int'(exp));
    repeat (12) @(negedge clk);
  endtask

  task automatic t_baud();
    int cnt;
    bus_write(3'd2, 8'h06);
    bus_write(3'd1, 8'h08);
    bus_write(3'd0, 8'h00);
    bus_write(3'd4, 8'h01);
    bus_write(3'd6, 8'h01);
    measure_start(cnt);
    chk(cnt == 32, "R5 normal speed divisor 1", cnt, 32);
    repeat (10*32) @(negedge clk);
    bus_write(3'd0, 8'h02);
    bus_write(3'd4, 8'h02);
    bus_write(3'd6, 8'h01);
    measure_start(cnt);
    chk(cnt == 24, "R5 double speed divisor 2", cnt, 24);
    repeat (10*24) @(negedge clk);
    bus_write(3'd4, 8'h00);
  endtask

  task automatic t_txc();
    logic [7:0] rd;
    bus_write(3'd0, 8'h42);
    bus_read(3'd0, rd);
    chk(rd[6] === 1'b0, "R8 cleared by writing 1", int'(rd[6]), 0);
    bus_write(3'd6, 8'h3C);
    repeat (20) @(negedge clk);
    bus_read(3'd0, rd);
    chk(rd[6] === 1'b0, "R8 clear during frame", int'(rd[6]), 0);
    repeat (10*8 + 10) @(negedge clk);
    bus_read(3'd0, rd);
    chk(rd[6] === 1'b1, "R8 set after drain", int'(rd[6]), 1);
    bus_write(3'd0, 8'h02);
    bus_read(3'd0, rd);
    chk(rd[6] === 1'b1, "R8 writing 0 keeps flag", int'(rd[6]), 1);
    bus_write(3'd0, 8'h42);
    bus_read(3'd0, rd);
    chk(rd[6] === 1'b0, "R8 writing 1 clears flag", int'(rd[6]), 0);
  endtask

  task automatic t_irq();
    logic [7:0] rd;
    bus_write(3'd1, 8'h48);
    bus_write(3'd6, 8'h5A);
    repeat (10*8 + 10) @(negedge clk);
    chk(irq_done === 1'b1, "R10 request raised", int'(irq_done), 1);
    pulse_ack(1'b0);
    chk(irq_done === 1'b0, "R10 request dropped by ack", int'(irq_done), 0);
    bus_read(3'd0, rd);
    chk(rd[6] === 1'b0, "R10 flag cleared by ack", int'(rd[6]), 0);
    bus_write(3'd1, 8'h28);
    chk(irq_empty === 1'b1, "R9 request raised", int'(irq_empty), 1);
    pulse_ack(1'b1);
    chk(irq_empty === 1'b0, "R9 request dropped by ack", int'(irq_empty), 0);
    bus_read(3'd0, rd);
    chk(rd[5] === 1'b0, "R9 flag cleared by ack", int'(rd[5]), 0);
    bus_write(3'd1, 8'h28);
    bus_read(3'd0, rd);
    chk(rd[5] === 1'b0, "R7 no edge, flag unchanged", int'(rd[5]), 0);
    bus_write(3'd1, 8'h20);
    bus_write(3'd1, 8'h28);
    bus_read(3'd0, rd);
    chk(rd[5] === 1'b1, "R7 enable edge sets flag", int'(rd[5]), 1);
  endtask

  task automatic t_b2b();
    logic [12:0] got, e1, e2;
    int len;
    bus_write(3'd2, 8'h06);
    bus_write(3'd1, 8'h28);
    e1 = exp_frame(9'h055, 8, 2'b00, 1'b0, len);
    e2 = exp_frame(9'h0C3, 8, 2'b00, 1'b0, len);
    bus_write(3'd6, 8'h55);
    bus_write(3'd6, 8'hC3);
    chk(irq_empty === 1'b0, "R6 empty flag cleared by pending write", int'(irq_empty), 0);
    capture(8, len, got);
    chk(got === e1, "R6 first of two frames", int'(got), int'(e1));
    capture(8, len, got);
    chk(got === e2, "R6 second of two frames", int'(got), int'(e2));
    repeat (12) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_regs();
    t_disabled();
    t_frame("R2 8 bits no parity", 8'hA5, 1'b0, 3'd3, 2'b00, 1'b0);
    t_frame("R4 5 bits even parity two stops", 8'h16, 1'b0, 3'd0, 2'b10, 1'b1);
    t_frame("R4 7 bits odd parity", 8'h4D, 1'b0, 3'd2, 2'b11, 1'b0);
    t_frame("R3 9 bits odd parity ninth set", 8'h3C, 1'b1, 3'd7, 2'b11, 1'b0);
    t_frame("R3 reserved code as 9 bits", 8'h81, 1'b1, 3'd5, 2'b00, 1'b0);
    t_frame("R4 parity mode 01 is none", 8'hE7, 1'b0, 3'd1, 2'b01, 1'b0);
    t_baud();
    t_txc();
    t_irq();
    t_b2b();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule